// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This unit forms the address of a memory operand as the sum of a sign-extended displacement, an optional base register value and an optional index register value multiplied by a power-of-two factor. Each of the three terms may be left out, so a single request path covers absolute, register-indirect, base-with-offset, indexed and scaled-indexed operands. The caller also names the register that supplies the index, so that the unit can refuse encodings that are not allowed.

One request is taken at a time over a valid/ready handshake. In address mode the computed address itself is returned, as a load-effective-address operation would write it to a register. In load mode the unit issues one read on a simple request/acknowledge memory port and returns the word that comes back. A request with an illegal encoding returns an error response and never touches memory. All response outputs come from registers and hold until the consumer takes them.

Top module: `scaled_ea_unit`

## Requirements
- R1: The address is the sign-extended displacement plus the base value plus the index value times the scale factor, all taken modulo 2^64.
- R2: A base with `req_has_base` = 0 and an index with `req_has_index` = 0 each add zero; a displacement length code of 00 adds zero whatever `req_disp` holds.
- R3: Displacement length codes 01, 10 and 11 take bits [7:0], [15:0] and [31:0] of `req_disp` respectively and sign-extend them to 64 bits.
- R4: `req_scale` carries the factor itself; with an index present only the values 1, 2, 4 and 8 are legal, any other value gives an error response and no memory read; with no index the field is ignored.
- R5: With an index present, an index selector equal to 4 (the stack pointer) gives an error response and no memory read; with no index the selector is ignored.
- R6: In address mode (`req_op` = 0) a legal request gets `rsp_valid` high in the cycle after acceptance, with `rsp_data` equal to the address, `rsp_err` low and no memory read.
- R7: In load mode (`req_op` = 1) a legal request raises `mem_rd_req` in the cycle after acceptance with `mem_addr` equal to the address; both hold until `mem_rd_ack`; `rsp_valid` rises in the cycle after the acknowledge with `rsp_data` equal to `mem_rd_data` as sampled at the acknowledge.
- R8: While `rsp_valid` is high and `rsp_ready` is low the response stays unchanged; `req_ready` is low from acceptance until the response has been taken.
- R9: An error response has `rsp_err` high and `rsp_data` equal to zero.
- R10: After reset `req_ready` is high and `rsp_valid` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 1 | 0 = return address, 1 = load from memory |
| req_has_base | input | 1 | Base term present |
| req_has_index | input | 1 | Index term present |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_index_sel | input | 4 | Number of the register supplying the index |
| req_scale | input | 4 | Scale factor value |
| req_disp | input | 32 | Displacement bits |
| req_disp_len | input | 2 | Displacement length: 00 none, 01 8-bit, 10 16-bit, 11 32-bit |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Address or loaded word |
| rsp_err | output | 1 | Request encoding was illegal |
| mem_rd_req | output | 1 | Memory read requested |
| mem_addr | output | 64 | Memory read address |
| mem_rd_ack | input | 1 | Memory returns data this cycle |
| mem_rd_data | input | 64 | Memory read data |

## Verification
Assertions watch, on every cycle, the sequencing around each handshake: that an illegal request turns into a zero-data error response with no read, that an address-mode request answers one cycle later with the address the adder produced, that a load raises the read with that address and holds it until acknowledged, that read data lands in the response one cycle after the acknowledge, and that a stalled response stays frozen. Whether the adder itself is right can only be shown by the bench's scenarios, which compare against a separately written model: the worked examples with known answers, each displacement width with negative values, every absent-term form, wrap-around past 2^64, each illegal scale and the stack-pointer index, and the ignored fields when no index is present.

// File: rtl/sea_pkg.sv
// Shared types for the scaled-index effective address unit.
// Assumes: one request in flight at a time.
package sea_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_READ = 2'b01,
        ST_RESP = 2'b10
    } sea_state_e;

    typedef enum logic [1:0] {
        DLEN_NONE = 2'b00,
        DLEN_B8   = 2'b01,
        DLEN_B16  = 2'b10,
        DLEN_B32  = 2'b11
    } disp_len_e;

    localparam logic OP_ADDR = 1'b0;
    localparam logic OP_LOAD = 1'b1;
endpackage

// File: rtl/sea_decode.sv
// Operand-form decoder: checks legality of the index encoding, turns the
// scale factor into a shift amount and sign-extends the displacement.
// Assumes: displacement field is 32 bits; ADDR_W is at least 32.
module sea_decode #(
    parameter int ADDR_W    = 64,
    parameter int SCALE_W   = 4,
    parameter int SEL_W     = 4,
    parameter int SP_SEL    = 4,
    parameter int MAX_SHIFT = 3,
    localparam int SH_W     = $clog2(MAX_SHIFT + 1),
    localparam int DISP_W   = 32
) (
    input  logic                has_index,
    input  logic [SEL_W-1:0]    index_sel,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [DISP_W-1:0]   disp,
    input  logic [1:0]          disp_len,
    output logic                legal,
    output logic [SH_W-1:0]     shamt,
    output logic [ADDR_W-1:0]   disp_ext
);
    import sea_pkg::*;

    logic [MAX_SHIFT:0] scale_hit;
    logic               scale_ok;
    logic               index_ok;

    // One comparator per legal power-of-two factor.
    for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_scale
        assign scale_hit[k] = (scale == SCALE_W'(1 << k));
    end

    // Encode the matching factor into a shift count.
    always_comb begin
        shamt = '0;
        for (int k = 0; k <= MAX_SHIFT; k++) begin
            if (scale_hit[k]) shamt = SH_W'(k);
        end
    end

    assign scale_ok = |scale_hit;
    assign index_ok = (index_sel != SEL_W'(SP_SEL));
    assign legal    = !has_index || (scale_ok && index_ok);

    // Sign-extend the displacement from the selected width.
    always_comb begin
        case (disp_len_e'(disp_len))
            DLEN_B8:  disp_ext = {{(ADDR_W-8){disp[7]}},   disp[7:0]};
            DLEN_B16: disp_ext = {{(ADDR_W-16){disp[15]}}, disp[15:0]};
            DLEN_B32: disp_ext = {{(ADDR_W-32){disp[31]}}, disp[31:0]};
            default:  disp_ext = '0;
        endcase
    end
endmodule

// File: rtl/sea_agen.sv
// Address adder: displacement + optional base + optional shifted index,
// wrapping modulo 2^ADDR_W.
// Assumes: shamt already validated by the decoder.
module sea_agen #(
    parameter int ADDR_W = 64,
    parameter int SH_W   = 2
) (
    input  logic              has_base,
    input  logic              has_index,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [SH_W-1:0]   shamt,
    input  logic [ADDR_W-1:0] disp_ext,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;

    // Gate absent terms to zero, then sum the three terms.
    always_comb begin
        base_term  = has_base  ? base_val : '0;
        index_term = has_index ? (index_val << shamt) : '0;
        ea         = disp_ext + base_term + index_term;
    end
endmodule

// File: rtl/sea_ctrl.sv
// Request sequencer: accepts one request, answers at once for address mode
// or errors, otherwise runs one memory read and returns its data.
// Assumes: memory holds data valid in the cycle mem_rd_ack is high.
module sea_ctrl #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              legal,
    input  logic [ADDR_W-1:0] ea,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data
);
    import sea_pkg::*;

    sea_state_e        state_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign accept     = req_valid && req_ready;
    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = (state_q == ST_RESP);
    assign mem_rd_req = (state_q == ST_READ);
    assign rsp_data   = data_q;
    assign rsp_err    = err_q;
    assign mem_addr   = addr_q;

    // State, response and read-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            err_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!legal) begin
                            data_q  <= '0;
                            err_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end else if (req_op == OP_LOAD) begin
                            addr_q  <= ea;
                            err_q   <= 1'b0;
                            state_q <= ST_READ;
                        end else begin
                            data_q  <= DATA_W'(ea);
                            err_q   <= 1'b0;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rd_ack) begin
                        data_q  <= mem_rd_data;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4 R5 R9
    illegal_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !legal |=> rsp_valid && rsp_err && rsp_data == '0 && !mem_rd_req);

    // R6
    addr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && legal && req_op == OP_ADDR |=>
            rsp_valid && !rsp_err && rsp_data == DATA_W'($past(ea)) && !mem_rd_req);

    // R7
    load_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && legal && req_op == OP_LOAD |=> mem_rd_req && mem_addr == $past(ea));

    // R7
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_addr));

    // R7
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_ack |=> rsp_valid && rsp_data == $past(mem_rd_data));

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
endmodule

// File: rtl/scaled_ea_unit.sv
// Top of the scaled-index effective address unit: decoder, adder and
// sequencer. Returns either the address or the word loaded from it.
// Assumes: one outstanding request; synchronous active-low reset.
module scaled_ea_unit #(
    parameter int ADDR_W    = 64,
    parameter int DATA_W    = 64,
    parameter int SEL_W     = 4,
    parameter int SCALE_W   = 4,
    parameter int SP_SEL    = 4,
    parameter int MAX_SHIFT = 3,
    localparam int SH_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic               req_has_base,
    input  logic               req_has_index,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [ADDR_W-1:0]  req_index,
    input  logic [SEL_W-1:0]   req_index_sel,
    input  logic [SCALE_W-1:0] req_scale,
    input  logic [31:0]        req_disp,
    input  logic [1:0]         req_disp_len,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_err,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rd_ack,
    input  logic [DATA_W-1:0]  mem_rd_data
);
    logic              legal;
    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] ea;

    sea_decode #(
        .ADDR_W(ADDR_W), .SCALE_W(SCALE_W), .SEL_W(SEL_W),
        .SP_SEL(SP_SEL), .MAX_SHIFT(MAX_SHIFT)
    ) u_decode (
        .has_index (req_has_index),
        .index_sel (req_index_sel),
        .scale     (req_scale),
        .disp      (req_disp),
        .disp_len  (req_disp_len),
        .legal     (legal),
        .shamt     (shamt),
        .disp_ext  (disp_ext)
    );

    sea_agen #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_agen (
        .has_base  (req_has_base),
        .has_index (req_has_index),
        .base_val  (req_base),
        .index_val (req_index),
        .shamt     (shamt),
        .disp_ext  (disp_ext),
        .ea        (ea)
    );

    sea_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .legal       (legal),
        .ea          (ea),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data),
        .rsp_err     (rsp_err),
        .mem_rd_req  (mem_rd_req),
        .mem_addr    (mem_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data)
    );
endmodule

// File: tb/tb_scaled_ea_unit.sv
module tb_scaled_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic        req_has_base = 1'b0;
    logic        req_has_index = 1'b0;
    logic [63:0] req_base = '0;
    logic [63:0] req_index = '0;
    logic [3:0]  req_index_sel = '0;
    logic [3:0]  req_scale = '0;
    logic [31:0] req_disp = '0;
    logic [1:0]  req_disp_len = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;
    logic        rsp_err;
    logic        mem_rd_req;
    logic [63:0] mem_addr;
    logic        mem_rd_ack = 1'b0;
    logic [63:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int reads_seen = 0;
    int reads_exp = 0;
    bit finished = 1'b0;

    logic [63:0] exp_data_q[$];
    logic        exp_err_q[$];
    string       exp_tag_q[$];
    logic [63:0] exp_addr_q[$];

    always #10 clk = ~clk;

    scaled_ea_unit dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0], a[63:32]} ^ 64'h5A3C_96E1_0F24_B7D8;
    endfunction

    // Model of the address from the requirement text.
    function automatic logic [63:0] model_ea(input bit hb, input bit hi, input logic [63:0] b,
        input logic [63:0] x, input logic [3:0] s, input logic [31:0] d, input logic [1:0] dl);
        logic signed [63:0] dv;
        logic [63:0] sum;
        case (dl)
            2'b01:   dv = 64'($signed(d[7:0]));
            2'b10:   dv = 64'($signed(d[15:0]));
            2'b11:   dv = 64'($signed(d));
            default: dv = 64'sd0;
        endcase
        sum = 64'(dv);
        if (hb) sum = sum + b;
        if (hi) sum = sum + x * 64'(s);
        return sum;
    endfunction

    // Driver: predict, push expectations, drive one request.
    task automatic send(input bit op, input bit hb, input bit hi, input logic [63:0] b,
        input logic [63:0] x, input logic [3:0] sel, input logic [3:0] s,
        input logic [31:0] d, input logic [1:0] dl, input string tag);
        bit ok;
        logic [63:0] a;
        ok = !hi || ((s == 1 || s == 2 || s == 4 || s == 8) && sel != 4'd4);
        a  = model_ea(hb, hi, b, x, s, d, dl);
        exp_err_q.push_back(!ok);
        exp_tag_q.push_back(tag);
        if (!ok)            exp_data_q.push_back(64'd0);
        else if (op == 1'b0) exp_data_q.push_back(a);
        else begin
            exp_data_q.push_back(mem_word(a));
            exp_addr_q.push_back(a);
            reads_exp++;
        end
        req_op = op; req_has_base = hb; req_has_index = hi; req_base = b; req_index = x;
        req_index_sel = sel; req_scale = s; req_disp = d; req_disp_len = dl;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok || op == 1'b0)
            chk(rsp_valid === 1'b1 && mem_rd_req === 1'b0, {tag, " R6 one-cycle response, no read"},
                64'({rsp_valid, mem_rd_req}), 64'b10);
    endtask

    // Memory model: checks address against expected loads, answers after a delay.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_req) begin
                reads_seen++;
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R4/R5/R6 unexpected memory read", mem_addr, 64'd0);
                end else begin
                    logic [63:0] ea_exp;
                    ea_exp = exp_addr_q.pop_front();
                    chk(mem_addr === ea_exp, "R7 read address", mem_addr, ea_exp);
                end
                repeat (dly) @(negedge clk);
                dly = (dly + 1) % 3;
                mem_rd_ack = 1'b1;
                mem_rd_data = mem_word(mem_addr);
                @(negedge clk);
                mem_rd_ack = 1'b0;
                mem_rd_data = '0;
                chk(rsp_valid === 1'b1 && mem_rd_req === 1'b0, "R7 response one cycle after ack",
                    64'({rsp_valid, mem_rd_req}), 64'b10);
            end
        end
    end

    // Monitor: scoreboard compare, stall pattern and hold check.
    initial begin
        bit shown = 1'b0;
        int stall = 0;
        logic [63:0] held_d;
        logic held_e;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rsp_ready = 1'b0;
            end else if (rsp_valid) begin
                if (!shown) begin
                    if (exp_data_q.size() == 0) begin
                        chk(1'b0, "R6/R7 unexpected response", rsp_data, 64'd0);
                    end else begin
                        logic [63:0] ed;
                        logic ee;
                        string tg;
                        ed = exp_data_q.pop_front();
                        ee = exp_err_q.pop_front();
                        tg = exp_tag_q.pop_front();
                        chk(rsp_data === ed, {tg, " data"}, rsp_data, ed);
                        chk(rsp_err === ee, {tg, " error flag (R9)"}, 64'(rsp_err), 64'(ee));
                    end
                    held_d = rsp_data;
                    held_e = rsp_err;
                    shown = 1'b1;
                end else begin
                    chk(rsp_data === held_d && rsp_err === held_e, "R8 response held under stall",
                        rsp_data, held_d);
                end
                chk(req_ready === 1'b0, "R8 no acceptance while response pending",
                    64'(req_ready), 64'd0);
                stall++;
                rsp_ready = (stall % 3) != 0;
                if (rsp_ready) shown = 1'b0;
            end else begin
                rsp_ready = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_req === 1'b0, "R10 reset outputs",
            64'({req_ready, rsp_valid, mem_rd_req}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 worked examples
        send(0, 1, 1, 64'h200, 64'h100, 4'd1, 4'd4, 32'h10, 2'b01, "R1 base+4*idx+disp");
        send(0, 0, 1, 64'hDEAD, 64'hF000, 4'd2, 4'd2, 32'h80, 2'b10, "R1 R2 no base 2*idx+disp");
        // R2 absent terms
        send(0, 0, 0, 64'h1111, 64'h2222, 4'd4, 4'd7, 32'h1234_5678, 2'b11, "R2 absolute");
        send(0, 1, 0, 64'h4000, 64'h5, 4'd4, 4'd0, 32'hFFFF_FFFF, 2'b00, "R2 indirect disp ignored");
        // R3 sign extension
        send(0, 1, 0, 64'h1000, 64'h0, 4'd0, 4'd1, 32'hABCD_12F0, 2'b01, "R3 8-bit negative disp");
        send(0, 0, 0, 64'h0, 64'h0, 4'd0, 4'd1, 32'h0000_8000, 2'b10, "R3 16-bit negative disp");
        send(0, 1, 0, 64'h1, 64'h0, 4'd0, 4'd1, 32'hFFFF_FFFF, 2'b11, "R1 R3 32-bit wrap to zero");
        send(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h2000_0000_0000_0003, 4'd9, 4'd8, 32'h7F, 2'b01,
             "R1 modulo wrap scale 8");
        send(0, 0, 1, 64'h0, 64'h77, 4'd3, 4'd1, 32'h0, 2'b00, "R1 scale 1 index only");
        // R4 illegal scales and ignored scale
        send(0, 1, 1, 64'h100, 64'h10, 4'd1, 4'd3, 32'h0, 2'b00, "R4 scale 3 illegal");
        send(1, 1, 1, 64'h100, 64'h10, 4'd1, 4'd0, 32'h0, 2'b00, "R4 R9 load scale 0 illegal");
        send(0, 1, 0, 64'h300, 64'h10, 4'd1, 4'd5, 32'h4, 2'b01, "R4 scale ignored without index");
        // R5 stack-pointer index
        send(1, 1, 1, 64'h100, 64'h10, 4'd4, 4'd2, 32'h0, 2'b00, "R5 R9 stack-pointer index");
        send(0, 1, 0, 64'h500, 64'h10, 4'd4, 4'd2, 32'h0, 2'b00, "R5 selector ignored without index");
        // R7 loads
        send(1, 1, 1, 64'h200, 64'h100, 4'd1, 4'd4, 32'h10, 2'b01, "R7 load 0x610");
        send(1, 0, 1, 64'h0, 64'hF000, 4'd2, 4'd2, 32'h80, 2'b10, "R7 load no base");
        send(1, 1, 0, 64'h8000_0000_0000_0000, 64'h0, 4'd0, 4'd1, 32'hFFFF_FF00, 2'b11, "R7 load negative disp");
        send(0, 1, 1, 64'h40, 64'h3, 4'd7, 4'd8, 32'h0, 2'b00, "R6 address after loads");

        while (exp_data_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(reads_seen == reads_exp, "R4/R5/R7 memory read count", 64'(reads_seen), 64'(reads_exp));
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule